// File: doc/BRIEF.md
# Flash Embedded-Operation Status Reporter

This block stands in for a byte-wide flash array while an embedded program or erase algorithm runs inside it. A command port accepts a byte program, a sector erase, a whole-array erase, or a clear of a failed operation. Once a command is accepted, the block counts off a fixed number of algorithm cycles, raises a busy output, and replaces array data with a polling status word on reads that hit the location or sector being worked on. Reads elsewhere return array contents as usual.

The cell physics is reduced to a cycle count. A `cell_hold` input stalls the algorithm's progress to model a cell that will not settle. A separate time-out counter keeps running while the progress counter is stalled. The status word has three meaningful bits. Bit 7 is a polarity bit that resolves when the work is done. Bit 6 flips on every status read. Bit 5 is a sticky error flag. An operation that sets the error flag stays in a failed state, still reporting status, until a clear command arrives.

Top module: `fsr_flash_status`

## Requirements
- R1: After reset, `busy` is 0 and every byte reads FFh. A read presented with `rd_en` high at one rising edge shows its result on `rd_data` after that edge.
- R2: An accepted program (cmd_op 2'b01) holds `busy` high for exactly OP_CYCLES cycles when `cell_hold` stays low. Afterwards the byte reads as old AND new, so programming only clears bits.
- R3: While a program runs, a read of its address returns a status word: bit 7 is the inverse of bit 7 of the program data, bit 5 is 0, and bits 4..0 are 0. Reads of any other address return array data.
- R4: A sector erase (cmd_op 2'b10) selects the sector given by the top SECT_W bits of `cmd_addr`. While it runs, a read of any byte in that sector returns status with bit 7 = 0 and bit 5 = 0. At the end, every byte of that sector reads FFh and other sectors are unchanged.
- R5: A whole-array erase (cmd_op 2'b11) makes reads of every address return status with bit 7 = 0 while it runs. At the end, every byte reads FFh.
- R6: Bit 6 of the status word inverts on each successive status read while an operation runs or has failed. Once an operation completes successfully, repeated reads return identical array data.
- R7: A program whose data has a 1 where the stored byte has a 0 runs the full OP_CYCLES cycles and then enters the failed state. In the failed state, `busy` is 0, status reads of that address show bit 5 = 1, and the stored byte becomes old AND new.
- R8: If progress has not finished within TIMEOUT_CYCLES cycles of acceptance, the operation fails with bit 5 = 1. A timed-out program still applies old AND new, and a timed-out erase leaves the array untouched. A stall that ends early enough only lengthens `busy` by the stalled cycles.
- R9: Any command arriving while an operation runs is ignored. In the failed state, only the clear command (cmd_op 2'b00) has an effect; it returns the block to idle with normal reads. A clear command while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 clear, 01 program, 10 sector erase, 11 whole-array erase |
| cmd_addr | input | ADDR_W | Byte address; its top SECT_W bits select the sector |
| cmd_data | input | DATA_W | Program data |
| cell_hold | input | 1 | Stalls algorithm progress while high |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read result, array data or status word |
| busy | output | 1 | High while an embedded operation runs |

## Verification
The bench measures the exact length of `busy` for a normal operation, a fully stalled one that must time out, and a partly stalled one that must still succeed. A design that lets the time-out counter pause with progress, or that counts the time-out from the wrong cycle, would report a different length or fail the wrong case. The bench programs a 1 over a cleared bit and then checks three things: the failure must appear only at the end, the stored byte must keep only the cleared bits, and other commands must have no effect until a clear. A design that wrote the raw data, or that let a new command pass in the failed state, would show the wrong byte or a second busy period. During erases, the bench reads the far edge of the erased sector and a byte in a neighbouring sector, which exposes sector decoding that uses the wrong address bits. It also checks that bit 6 alternates and then settles.

// File: rtl/fsr_pkg.sv
// Shared types for the flash status reporter.
// Assumes data words are at least 8 bits wide so the status bits exist.
package fsr_pkg;
    typedef enum logic [1:0] {
        OP_CLEAR      = 2'b00,
        OP_PROG       = 2'b01,
        OP_SECT_ERASE = 2'b10,
        OP_CHIP_ERASE = 2'b11
    } fsr_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_FAIL = 2'b10
    } fsr_state_e;

    localparam int BIT_POLL   = 7;
    localparam int BIT_TOGGLE = 6;
    localparam int BIT_ERR    = 5;
endpackage

// File: rtl/fsr_op_timer.sv
// Progress and time-out counters for one embedded operation.
// Progress advances on run cycles without hold; the time-out counter
// advances on every run cycle. Both clear on start. Assumes
// TIMEOUT_CYCLES > OP_CYCLES (checked in the top).
module fsr_op_timer #(
    parameter int OP_CYCLES      = 8,
    parameter int TIMEOUT_CYCLES = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    input  logic hold,
    output logic done,
    output logic expired
);
    localparam int PW = $clog2(OP_CYCLES + 1);
    localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

    logic [PW-1:0] prog_cnt;
    logic [TW-1:0] tmo_cnt;

    // Count algorithm progress and elapsed run time.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            prog_cnt <= '0;
            tmo_cnt  <= '0;
        end else if (run) begin
            tmo_cnt <= tmo_cnt + 1'b1;
            if (!hold) begin
                prog_cnt <= prog_cnt + 1'b1;
            end
        end
    end

    // Finish when the last progress step is taken; expire otherwise.
    always_comb begin
        done    = run && !hold && (prog_cnt == PW'(OP_CYCLES - 1));
        expired = run && !done && (tmo_cnt == TW'(TIMEOUT_CYCLES - 1));
    end

    // R2: progress never runs past the nominal length
    p_prog_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (int'(prog_cnt) < OP_CYCLES));
    // R8: the time-out window is never exceeded
    p_tmo_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (int'(tmo_cnt) < TIMEOUT_CYCLES));
    // R8: elapsed time is never behind progress
    p_tmo_ge_prog_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (int'(tmo_cnt) >= int'(prog_cnt)));
endmodule

// File: rtl/fsr_cell_array.sv
// Byte array with clear-only programming and sector/whole erase.
// Each word is its own register; reset and erase set words to all ones.
// Assumes program and erase strobes are single-cycle and exclusive.
module fsr_cell_array #(
    parameter int ADDR_W = 6,
    parameter int SECT_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              sect_erase,
    input  logic              chip_erase,
    input  logic [SECT_W-1:0] sect_sel,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    input  logic [ADDR_W-1:0] cmp_addr,
    output logic [DATA_W-1:0] cmp_word
);
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int SECT_LSB = ADDR_W - SECT_W;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        localparam logic [SECT_W-1:0] W_SECT = SECT_W'(g >> SECT_LSB);
        logic [DATA_W-1:0] cell_q;
        logic              erase_hit;
        logic              prog_hit;

        // Decode whether this word is erased or programmed this cycle.
        always_comb begin
            erase_hit = chip_erase || (sect_erase && (sect_sel == W_SECT));
            prog_hit  = prog_we && (prog_addr == ADDR_W'(g));
        end

        // Hold one byte; erase sets ones, programming only clears bits.
        always_ff @(posedge clk) begin
            if (!rst_n || erase_hit) begin
                cell_q <= '1;
            end else if (prog_hit) begin
                cell_q <= cell_q & prog_data;
            end
        end

        assign mem[g] = cell_q;

        // R2: a program never turns a 0 bit into a 1
        p_clear_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (prog_hit && !erase_hit) |=> ((cell_q & ~$past(cell_q)) == '0));
        // R4: an erased word reads all ones afterwards
        p_erase_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
            erase_hit |=> (cell_q == '1));
    end

    assign rd_word  = mem[rd_addr];
    assign cmp_word = mem[cmp_addr];
endmodule

// File: rtl/fsr_status_mux.sv
// Registered read path: picks array data or the polling status word.
// A read hits when an operation runs or has failed and the address is
// the program target, lies in the erased sector, or a whole erase runs.
// The toggle bit flips on every status read served.
module fsr_status_mux #(
    parameter int ADDR_W = 6,
    parameter int SECT_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              active,
    input  logic              failed,
    input  logic              is_prog,
    input  logic              is_chip,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              poll_bit,
    input  logic [DATA_W-1:0] array_word,
    output logic [DATA_W-1:0] rd_data
);
    import fsr_pkg::*;

    localparam int SECT_LSB = ADDR_W - SECT_W;

    logic              hit;
    logic              tog_q;
    logic [DATA_W-1:0] status_word;

    // Decide whether a read lands on the region under operation.
    always_comb begin
        if (is_prog) begin
            hit = active && (rd_addr == tgt_addr);
        end else begin
            hit = active && (is_chip ||
                  (rd_addr[ADDR_W-1:SECT_LSB] == tgt_addr[ADDR_W-1:SECT_LSB]));
        end
    end

    // Assemble the status word from polarity, toggle and error bits.
    always_comb begin
        status_word             = '0;
        status_word[BIT_POLL]   = poll_bit;
        status_word[BIT_TOGGLE] = tog_q;
        status_word[BIT_ERR]    = failed;
    end

    // Register the read result and advance the toggle on status reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            tog_q   <= 1'b0;
        end else if (rd_en) begin
            if (hit) begin
                rd_data <= status_word;
                tog_q   <= ~tog_q;
            end else begin
                rd_data <= array_word;
            end
        end
    end

    // R3: the low status bits are always zero
    p_status_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit) |=> (rd_data[4:0] == '0));
    // R4: erase status shows polarity bit low
    p_erase_poll_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit && !is_prog) |=> !rd_data[BIT_POLL]);
    // R6: consecutive status reads differ in the toggle bit
    p_toggle_flips_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit) |=> (rd_data[BIT_TOGGLE] != tog_q));
    // R7: a failed operation reports the error bit
    p_fail_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit && failed) |=> rd_data[BIT_ERR]);
endmodule

// File: rtl/fsr_flash_status.sv
// Top of the flash status reporter. Accepts one command while idle,
// runs it through the operation timer, applies the array change at the
// end, and enters a failed state on time-out or on a program that would
// need a 0 bit raised. Only the clear command leaves the failed state.
module fsr_flash_status #(
    parameter int ADDR_W         = 6,
    parameter int SECT_W         = 2,
    parameter int DATA_W         = 8,
    parameter int OP_CYCLES      = 8,
    parameter int TIMEOUT_CYCLES = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cell_hold,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);
    import fsr_pkg::*;

    localparam int SECT_LSB = ADDR_W - SECT_W;

    if (TIMEOUT_CYCLES <= OP_CYCLES || DATA_W < 8 || SECT_W > ADDR_W) begin : g_bad_cfg
        $error("fsr_flash_status: invalid parameter set");
    end

    fsr_state_e        state_q;
    fsr_op_e           op_q;
    logic [ADDR_W-1:0] tgt_addr_q;
    logic [DATA_W-1:0] tgt_data_q;

    logic              run;
    logic              accept;
    logic              clear_cmd;
    logic              done;
    logic              expired;
    logic              bad_bits;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] cmp_word;
    logic              prog_we;
    logic              sect_erase;
    logic              chip_erase;
    logic              poll_bit;

    // Decode command acceptance and array strobes.
    always_comb begin
        run        = (state_q == ST_RUN);
        accept     = cmd_valid && (state_q == ST_IDLE) && (fsr_op_e'(cmd_op) != OP_CLEAR);
        clear_cmd  = cmd_valid && (fsr_op_e'(cmd_op) == OP_CLEAR);
        bad_bits   = |(tgt_data_q & ~cmp_word);
        prog_we    = run && (op_q == OP_PROG) && (done || expired);
        sect_erase = run && (op_q == OP_SECT_ERASE) && done;
        chip_erase = run && (op_q == OP_CHIP_ERASE) && done;
        poll_bit   = (op_q == OP_PROG) ? ~tgt_data_q[BIT_POLL] : 1'b0;
        busy       = run;
    end

    // Operation state machine: idle, running, failed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            op_q       <= OP_PROG;
            tgt_addr_q <= '0;
            tgt_data_q <= '1;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q    <= ST_RUN;
                        op_q       <= fsr_op_e'(cmd_op);
                        tgt_addr_q <= cmd_addr;
                        tgt_data_q <= cmd_data;
                    end
                end
                ST_RUN: begin
                    if (expired) begin
                        state_q <= ST_FAIL;
                    end else if (done) begin
                        state_q <= (op_q == OP_PROG && bad_bits) ? ST_FAIL : ST_IDLE;
                    end
                end
                ST_FAIL: begin
                    if (clear_cmd) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    fsr_op_timer #(
        .OP_CYCLES      (OP_CYCLES),
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .run     (run),
        .hold    (cell_hold),
        .done    (done),
        .expired (expired)
    );

    fsr_cell_array #(
        .ADDR_W (ADDR_W),
        .SECT_W (SECT_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_we    (prog_we),
        .prog_addr  (tgt_addr_q),
        .prog_data  (tgt_data_q),
        .sect_erase (sect_erase),
        .chip_erase (chip_erase),
        .sect_sel   (tgt_addr_q[ADDR_W-1:SECT_LSB]),
        .rd_addr    (rd_addr),
        .rd_word    (rd_word),
        .cmp_addr   (tgt_addr_q),
        .cmp_word   (cmp_word)
    );

    fsr_status_mux #(
        .ADDR_W (ADDR_W),
        .SECT_W (SECT_W),
        .DATA_W (DATA_W)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .active     (state_q != ST_IDLE),
        .failed     (state_q == ST_FAIL),
        .is_prog    (op_q == OP_PROG),
        .is_chip    (op_q == OP_CHIP_ERASE),
        .tgt_addr   (tgt_addr_q),
        .poll_bit   (poll_bit),
        .array_word (rd_word),
        .rd_data    (rd_data)
    );

    // R2: an accepted command makes the block busy on the next cycle
    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    // R7: the failed state persists until a clear command
    p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAIL && !clear_cmd) |=> (state_q == ST_FAIL));
    // R9: a running operation keeps its target despite new commands
    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !done && !expired) |=> (busy && $stable(tgt_addr_q) && $stable(op_q)));
    // R7: failure is never entered before the nominal end without a time-out
    p_fail_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !done && !expired) |=> (state_q != ST_FAIL));
endmodule

// File: tb/fsr_flash_status_test.sv
// Directed bench for the flash status reporter.
module fsr_flash_status_test;
    localparam int ADDR_W = 6;
    localparam int SECT_W = 2;
    localparam int DATA_W = 8;
    localparam int OPC    = 8;
    localparam int TMO    = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'b00;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [DATA_W-1:0] cmd_data = '0;
    logic              cell_hold = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              busy;

    int checks = 0;
    int errors = 0;
    int busy_cnt = 0;
    bit finished = 1'b0;

    fsr_flash_status #(
        .ADDR_W (ADDR_W), .SECT_W (SECT_W), .DATA_W (DATA_W),
        .OP_CYCLES (OPC), .TIMEOUT_CYCLES (TMO)
    ) uut (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
        .cmd_addr (cmd_addr), .cmd_data (cmd_data), .cell_hold (cell_hold),
        .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data), .busy (busy)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) if (busy) busy_cnt++;

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input int addr, input int data);
        cmd_valid = 1'b1; cmd_op = op;
        cmd_addr = ADDR_W'(addr); cmd_data = DATA_W'(data);
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic rd(input int addr, output int val);
        rd_en = 1'b1; rd_addr = ADDR_W'(addr);
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        val = int'(rd_data);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 busy after reset", int'(busy), 0);
        rd(0, v);  chk("R1 addr0 erased", v, 'hFF);
        rd(63, v); chk("R1 addr63 erased", v, 'hFF);
    endtask

    task automatic t_program();
        int v;
        busy_cnt = 0;
        issue(2'b01, 5, 'hA5);
        rd(5, v); chk("R3 program status", v & 'hBF, 'h00);
        rd(6, v); chk("R3 other address data", v, 'hFF);
        wait_idle();
        chk("R2 program busy length", busy_cnt, OPC);
        rd(5, v); chk("R2 programmed byte", v, 'hA5);
        busy_cnt = 0;
        issue(2'b01, 5, 'h21);
        wait_idle();
        chk("R2 second busy length", busy_cnt, OPC);
        rd(5, v); chk("R2 reprogram clears bits", v, 'h21);
    endtask

    task automatic t_bad_program();
        int v;
        busy_cnt = 0;
        issue(2'b01, 5, 'h80);
        rd(5, v); chk("R3 status before failure", v & 'hBF, 'h00);
        wait_idle();
        chk("R7 full length before failure", busy_cnt, OPC);
        rd(5, v); chk("R7 error bit set", v & 'hBF, 'h20);
        rd(6, v); chk("R7 other address normal", v, 'hFF);
        issue(2'b01, 6, 'h00);
        chk("R9 no start while failed", int'(busy), 0);
        rd(6, v); chk("R9 ignored program leaves byte", v, 'hFF);
        issue(2'b00, 0, 0);
        rd(5, v); chk("R7 byte keeps only cleared bits", v, 'h00);
        issue(2'b00, 0, 0);
        chk("R9 clear while idle no busy", int'(busy), 0);
        rd(5, v); chk("R9 clear while idle no change", v, 'h00);
    endtask

    task automatic t_toggle();
        int a, b, c;
        issue(2'b01, 10, 'h7F);
        rd(10, a); rd(10, b); rd(10, c);
        chk("R6 toggle first flip", int'(a[6] != b[6]), 1);
        chk("R6 toggle second flip", int'(b[6] != c[6]), 1);
        chk("R3 polarity inverted", a & 'hBF, 'h80);
        wait_idle();
        rd(10, a); rd(10, b);
        chk("R6 settled data", a, 'h7F);
        chk("R6 no toggle when done", b, 'h7F);
    endtask

    task automatic t_sector();
        int v;
        issue(2'b01, 17, 'h00); wait_idle();
        issue(2'b01, 40, 'h0F); wait_idle();
        busy_cnt = 0;
        issue(2'b10, 20, 0);
        rd(17, v); chk("R4 sector status", v & 'hBF, 'h00);
        rd(31, v); chk("R4 sector edge status", v & 'hBF, 'h00);
        rd(40, v); chk("R4 other sector data", v, 'h0F);
        issue(2'b01, 40, 'h00);
        wait_idle();
        chk("R9 busy length unaffected", busy_cnt, OPC);
        rd(17, v); chk("R4 sector byte erased", v, 'hFF);
        rd(31, v); chk("R4 sector edge erased", v, 'hFF);
        rd(40, v); chk("R9 command during erase ignored", v, 'h0F);
        rd(10, v); chk("R4 sector 0 untouched", v, 'h7F);
    endtask

    task automatic t_chip();
        int v;
        busy_cnt = 0;
        issue(2'b11, 0, 0);
        rd(40, v); chk("R5 whole erase status", v & 'hBF, 'h00);
        rd(63, v); chk("R5 whole erase status top", v & 'hBF, 'h00);
        wait_idle();
        chk("R5 busy length", busy_cnt, OPC);
        rd(40, v); chk("R5 erased 40", v, 'hFF);
        rd(10, v); chk("R5 erased 10", v, 'hFF);
    endtask

    task automatic t_timeout();
        int v;
        cell_hold = 1'b1;
        busy_cnt = 0;
        issue(2'b01, 3, 'h3C);
        wait_idle();
        chk("R8 program time-out length", busy_cnt, TMO);
        rd(3, v); chk("R8 time-out status", v & 'hBF, 'hA0);
        issue(2'b00, 0, 0);
        rd(3, v); chk("R8 time-out program applied", v, 'h3C);
        busy_cnt = 0;
        issue(2'b10, 0, 0);
        wait_idle();
        chk("R8 erase time-out length", busy_cnt, TMO);
        rd(3, v); chk("R8 erase time-out status", v & 'hBF, 'h20);
        cell_hold = 1'b0;
        issue(2'b00, 0, 0);
        rd(3, v); chk("R8 timed-out erase leaves data", v, 'h3C);
        busy_cnt = 0;
        cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = 6'd4; cmd_data = 8'h55;
        cell_hold = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (5) @(negedge clk);
        cell_hold = 1'b0;
        wait_idle();
        chk("R8 partial stall length", busy_cnt, OPC + 5);
        rd(4, v); chk("R8 partial stall succeeds", v, 'h55);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_program();
        t_bad_program();
        t_toggle();
        t_sector();
        t_chip();
        t_timeout();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule